// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This controller moves a processor core between four graded operating modes: full-speed active, doze, nap and sleep. Software picks the target mode by writing a small register port. The controller then steps through an ordered sequence that drives the clock enables, the supply-level select, the core power switch, the isolation clamps and the state-retention strobes. Each deeper mode stops more of the chip. Doze stops only the core clock. Nap also stops the PLL and bus snooping and lowers the supply level. Sleep stops every clock and opens the core supply switch, with isolation and retention around it.

Powering up after a switch-off has two timed waits. The first is a settle wait, so that rush current dies away. The second is a PLL lock wait, which ends before any clock is enabled again. Both are 16-bit cycle counts that software programs. A wake-up event from outside returns the core to active mode. A request that arrives while a sequence is running is held and carried out afterwards. A move between two low-power modes first climbs all the way back to active and then descends to the new mode.

Top module: `pms_ctrl`

## Requirements
- R1: After reset the controller is in mode 0 (active). busy is low. core_clk_en, pll_en, snoop_en and pwr_sw_en are high. vsel_low, iso_en, ret_save and ret_restore are low.
- R2: When settled in mode 1 (doze), only core_clk_en is low. pll_en, snoop_en and pwr_sw_en stay high, and vsel_low and iso_en stay low.
- R3: When settled in mode 2 (nap), core_clk_en, pll_en and snoop_en are low and vsel_low is high. The switch stays closed (pwr_sw_en high) and iso_en is low. core_clk_en is never high while pll_en is low.
- R4: When settled in mode 3 (sleep), all three clock enables are low, vsel_low is high, pwr_sw_en is low and iso_en is high.
- R5: Sleep entry from active runs one step per cycle in this order: the clocks stop, then iso_en rises, then ret_save gives a one-cycle pulse, then pwr_sw_en falls.
- R6: Sleep exit runs in this order. pwr_sw_en rises. ret_restore gives a one-cycle pulse SETTLE+1 cycles later. iso_en falls two cycles after the pulse. pll_en rises (with vsel_low falling) one cycle after that. core_clk_en rises LOCK+2 cycles after pll_en.
- R7: A wake_evt pulse returns the controller to active from doze, nap or sleep. In active mode it has no effect.
- R8: busy goes high the cycle after a request is taken and stays high until the sequence ends. cur_mode changes only while busy is high and reports the final mode once busy falls.
- R9: A mode request written while busy is held. It is carried out after the current sequence completes.
- R10: A request for the mode already in effect starts no sequence: busy stays low and no output moves.
- R11: iso_en is high whenever pwr_sw_en is low.
- R12: The write port decodes wr_addr 0 as the mode request (wr_data[1:0]), wr_addr 1 as the 16-bit settle count and wr_addr 2 as the 16-bit PLL lock count.
- R13: A move between two low-power modes first completes the full exit to active, with core_clk_en rising, and then enters the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mode, 1 settle count, 2 lock count |
| wr_data | input | 16 | Write data |
| wake_evt | input | 1 | Wake-up event, returns the controller to active |
| cur_mode | output | 2 | Mode in effect: 0 active, 1 doze, 2 nap, 3 sleep |
| busy | output | 1 | Sequence in progress |
| core_clk_en | output | 1 | Core clock enable |
| pll_en | output | 1 | PLL enable |
| snoop_en | output | 1 | Bus snooping enable |
| vsel_low | output | 1 | Reduced supply level select |
| pwr_sw_en | output | 1 | Core power switch closed (supply on) |
| iso_en | output | 1 | Output isolation clamp enable |
| ret_save | output | 1 | Retention save strobe |
| ret_restore | output | 1 | Retention restore strobe |

## Verification
The bench measures the distance in cycles between each step of the sleep exit, using small programmed settle and lock counts. A settle or lock counter that is off by one would move ret_restore or core_clk_en by a cycle, and an exit in the wrong order would release isolation before restore or enable the clock before the PLL. It writes a new request while a sleep entry is running, and checks that the held request is carried out afterwards rather than dropped or used to cut the sequence short. It checks that a same-mode request and a wake in active leave busy low. It checks that doze-to-nap passes through a running core clock, which a controller that jumped straight between low modes would skip.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [1:0] {
    M_ACT   = 2'd0,
    M_DOZE  = 2'd1,
    M_NAP   = 2'd2,
    M_SLEEP = 2'd3
  } pmode_t;

  typedef enum logic [3:0] {
    S_IDLE, S_EN_CLK, S_EN_ISO, S_EN_SAVE, S_EN_SW,
    S_EX_SW, S_EX_SETTLE, S_EX_REST, S_EX_ISO,
    S_EX_PLL, S_EX_LOCK, S_EX_CLK
  } pstate_t;
endpackage

// File: rtl/pms_cfg.sv
module pms_cfg #(
  parameter int CNT_W      = 16,
  parameter int ADDR_W     = 2,
  parameter int SETTLE_RST = 16,
  parameter int LOCK_RST   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              wake_evt,
  input  logic              consume,
  output logic [CNT_W-1:0]  settle_cnt,
  output logic [CNT_W-1:0]  lock_cnt,
  output logic              pend_valid,
  output logic [1:0]        pend_mode
);
  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SETTLE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_LOCK   = ADDR_W'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      settle_cnt <= CNT_W'(SETTLE_RST);
      lock_cnt   <= CNT_W'(LOCK_RST);
      pend_valid <= 1'b0;
      pend_mode  <= 2'd0;
    end else begin
      if (consume) pend_valid <= 1'b0;
      if (wr_en && wr_addr == A_MODE) begin
        pend_valid <= 1'b1;
        pend_mode  <= wr_data[1:0];
      end
      // a wake event outranks a software write in the same cycle
      if (wake_evt) begin
        pend_valid <= 1'b1;
        pend_mode  <= 2'd0;
      end
      if (wr_en && wr_addr == A_SETTLE) settle_cnt <= wr_data;
      if (wr_en && wr_addr == A_LOCK)   lock_cnt   <= wr_data;
    end
  end
endmodule

// File: rtl/pms_timer.sv
module pms_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/pms_ctrl.sv
module pms_ctrl #(
  parameter int CNT_W      = 16,
  parameter int ADDR_W     = 2,
  parameter int SETTLE_RST = 16,
  parameter int LOCK_RST   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              wake_evt,
  output logic [1:0]        cur_mode,
  output logic              busy,
  output logic              core_clk_en,
  output logic              pll_en,
  output logic              snoop_en,
  output logic              vsel_low,
  output logic              pwr_sw_en,
  output logic              iso_en,
  output logic              ret_save,
  output logic              ret_restore
);
  import pms_pkg::*;

  pstate_t          st_q;
  pmode_t           mode_q, tgt_q, pend_m;
  logic             pend_valid, consume, tmr_load, tmr_done;
  logic [1:0]       pend_raw;
  logic [CNT_W-1:0] settle_cnt, lock_cnt, tmr_val;
  logic             busy_q, clk_q, pll_q, snp_q, vlo_q, sw_q, iso_q, sav_q, rsr_q;

  pms_cfg #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .SETTLE_RST(SETTLE_RST), .LOCK_RST(LOCK_RST)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wake_evt(wake_evt), .consume(consume), .settle_cnt(settle_cnt),
    .lock_cnt(lock_cnt), .pend_valid(pend_valid), .pend_mode(pend_raw)
  );

  always_comb begin
    pend_m   = pmode_t'(pend_raw);
    consume  = (st_q == S_IDLE);
    tmr_load = (st_q == S_EX_SW) || (st_q == S_EX_PLL);
    tmr_val  = (st_q == S_EX_SW) ? settle_cnt : lock_cnt;
  end

  pms_timer #(.W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      mode_q <= M_ACT;
      tgt_q  <= M_ACT;
      busy_q <= 1'b0;
      clk_q  <= 1'b1;
      pll_q  <= 1'b1;
      snp_q  <= 1'b1;
      vlo_q  <= 1'b0;
      sw_q   <= 1'b1;
      iso_q  <= 1'b0;
      sav_q  <= 1'b0;
      rsr_q  <= 1'b0;
    end else begin
      sav_q <= 1'b0;
      rsr_q <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (pend_valid && pend_m != mode_q) begin
            busy_q <= 1'b1;
            tgt_q  <= pend_m;
            case (mode_q)
              M_ACT:   st_q <= S_EN_CLK;
              M_DOZE:  st_q <= S_EX_CLK;
              M_NAP:   st_q <= S_EX_PLL;
              default: st_q <= S_EX_SW;
            endcase
          end
        end
        S_EN_CLK: begin
          clk_q <= 1'b0;
          if (tgt_q != M_DOZE) begin
            pll_q <= 1'b0;
            snp_q <= 1'b0;
            vlo_q <= 1'b1;
          end
          if (tgt_q == M_SLEEP) begin
            st_q <= S_EN_ISO;
          end else begin
            st_q   <= S_IDLE;
            mode_q <= tgt_q;
            busy_q <= 1'b0;
          end
        end
        S_EN_ISO: begin
          iso_q <= 1'b1;
          st_q  <= S_EN_SAVE;
        end
        S_EN_SAVE: begin
          sav_q <= 1'b1;
          st_q  <= S_EN_SW;
        end
        S_EN_SW: begin
          sw_q   <= 1'b0;
          st_q   <= S_IDLE;
          mode_q <= tgt_q;
          busy_q <= 1'b0;
        end
        S_EX_SW: begin
          sw_q <= 1'b1;
          st_q <= S_EX_SETTLE;
        end
        S_EX_SETTLE: begin
          if (tmr_done) begin
            rsr_q <= 1'b1;
            st_q  <= S_EX_REST;
          end
        end
        S_EX_REST: st_q <= S_EX_ISO;
        S_EX_ISO: begin
          iso_q <= 1'b0;
          st_q  <= S_EX_PLL;
        end
        S_EX_PLL: begin
          vlo_q <= 1'b0;
          pll_q <= 1'b1;
          st_q  <= S_EX_LOCK;
        end
        S_EX_LOCK: begin
          if (tmr_done) st_q <= S_EX_CLK;
        end
        S_EX_CLK: begin
          clk_q  <= 1'b1;
          snp_q  <= 1'b1;
          mode_q <= M_ACT;
          if (tgt_q == M_ACT) begin
            busy_q <= 1'b0;
            st_q   <= S_IDLE;
          end else begin
            st_q <= S_EN_CLK;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign cur_mode    = mode_q;
  assign busy        = busy_q;
  assign core_clk_en = clk_q;
  assign pll_en      = pll_q;
  assign snoop_en    = snp_q;
  assign vsel_low    = vlo_q;
  assign pwr_sw_en   = sw_q;
  assign iso_en      = iso_q;
  assign ret_save    = sav_q;
  assign ret_restore = rsr_q;
endmodule

// File: rtl/pms_ctrl_chk.sv
module pms_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cur_mode,
  input logic       busy,
  input logic       core_clk_en,
  input logic       pll_en,
  input logic       snoop_en,
  input logic       vsel_low,
  input logic       pwr_sw_en,
  input logic       iso_en,
  input logic       ret_save,
  input logic       ret_restore
);
  p_iso_guard_r11: assert property (@(posedge clk) disable iff (rst)
    !pwr_sw_en |-> iso_en);

  p_sw_off_clocks_r4: assert property (@(posedge clk) disable iff (rst)
    !pwr_sw_en |-> (!core_clk_en && !pll_en && !snoop_en && vsel_low));

  p_save_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    ret_save |=> !ret_save);

  p_save_ctx_r5: assert property (@(posedge clk) disable iff (rst)
    ret_save |-> (iso_en && pwr_sw_en && !core_clk_en));

  p_restore_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    ret_restore |=> !ret_restore);

  p_restore_ctx_r6: assert property (@(posedge clk) disable iff (rst)
    ret_restore |-> (iso_en && pwr_sw_en && !pll_en));

  p_clk_needs_pll_r3: assert property (@(posedge clk) disable iff (rst)
    core_clk_en |-> pll_en);

  p_mode_moves_busy_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_mode) |-> $past(busy));

  p_doze_outputs_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && cur_mode == 2'd1) |-> (pll_en && snoop_en && !core_clk_en && pwr_sw_en));
endmodule

bind pms_ctrl pms_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cur_mode(cur_mode), .busy(busy),
  .core_clk_en(core_clk_en), .pll_en(pll_en), .snoop_en(snoop_en),
  .vsel_low(vsel_low), .pwr_sw_en(pwr_sw_en), .iso_en(iso_en),
  .ret_save(ret_save), .ret_restore(ret_restore)
);

// File: tb/pms_ctrl_bench.sv
`timescale 1ns/1ps
module pms_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        wake_evt = 1'b0;
  logic [1:0]  cur_mode;
  logic        busy, core_clk_en, pll_en, snoop_en, vsel_low;
  logic        pwr_sw_en, iso_en, ret_save, ret_restore;
  int n_chk = 0;
  int n_fail = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  pms_ctrl u_pms_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wake_evt(wake_evt), .cur_mode(cur_mode), .busy(busy),
    .core_clk_en(core_clk_en), .pll_en(pll_en), .snoop_en(snoop_en),
    .vsel_low(vsel_low), .pwr_sw_en(pwr_sw_en), .iso_en(iso_en),
    .ret_save(ret_save), .ret_restore(ret_restore)
  );

  // {mode, core, pll, snoop, vsel_low, sw, iso}
  localparam logic [7:0] VEC [10] = '{
    8'b01_011010, 8'b00_111010, 8'b10_000110, 8'b00_111010, 8'b11_000101,
    8'b00_111010, 8'b10_000110, 8'b01_011010, 8'b11_000101, 8'b10_000110
  };

  function automatic int pat_now();
    return int'({core_clk_en, pll_en, snoop_en, vsel_low, pwr_sw_en, iso_en});
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wake_pulse();
    @(negedge clk);
    wake_evt = 1'b1;
    @(negedge clk);
    wake_evt = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    int guard = 0;
    while (quiet < 3 && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (!busy) quiet++; else quiet = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int p0;
    bit quiet_ok;
    bit saw;
    int ci, ii, si, wi, scount;
    int swi, rsi, isi, pli, cki, rcount;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(pat_now() == 6'b111010, "R1 reset outputs", pat_now(), 6'b111010);
    chk(cur_mode == 2'd0 && !busy, "R1 reset mode/busy", {cur_mode, busy}, 0);
    chk(!ret_save && !ret_restore, "R1 strobes low", {ret_save, ret_restore}, 0);

    // R12 program short waits
    wr(2'd1, 16'd2);
    wr(2'd2, 16'd2);

    // table walk R2 R3 R4 R13
    for (int v = 0; v < 10; v++) begin
      wr(2'd0, {14'd0, VEC[v][7:6]});
      wait_idle();
      chk(cur_mode == VEC[v][7:6], "R8 mode after sequence", cur_mode, VEC[v][7:6]);
      chk(pat_now() == int'(VEC[v][5:0]), "R2/R3/R4 mode outputs", pat_now(), VEC[v][5:0]);
    end

    // back to active
    wake_pulse();
    wait_idle();
    chk(cur_mode == 2'd0, "R7 wake from nap", cur_mode, 0);

    // R5 sleep entry order
    wr(2'd1, 16'd5);
    wr(2'd2, 16'd3);
    wr(2'd0, 16'd3);
    ci = -1; ii = -1; si = -1; wi = -1; scount = 0;
    for (int i = 1; i < 40; i++) begin
      @(negedge clk);
      if (ci < 0 && !core_clk_en) ci = i;
      if (ii < 0 && iso_en) ii = i;
      if (si < 0 && ret_save) si = i;
      if (wi < 0 && !pwr_sw_en) wi = i;
      if (ret_save) scount++;
    end
    chk(ii - ci == 1, "R5 iso after clocks", ii - ci, 1);
    chk(si - ii == 1, "R5 save after iso", si - ii, 1);
    chk(wi - si == 1, "R5 switch after save", wi - si, 1);
    chk(scount == 1, "R5 save width", scount, 1);
    chk(cur_mode == 2'd3 && pat_now() == 6'b000101, "R4 sleep reached", pat_now(), 6'b000101);

    // R6 R12 sleep exit timing, settle 5 lock 3
    wr(2'd0, 16'd0);
    swi = -1; rsi = -1; isi = -1; pli = -1; cki = -1; rcount = 0;
    for (int i = 1; i < 60; i++) begin
      @(negedge clk);
      if (swi < 0 && pwr_sw_en) swi = i;
      if (rsi < 0 && ret_restore) rsi = i;
      if (isi < 0 && rsi >= 0 && !iso_en) isi = i;
      if (pli < 0 && pll_en) pli = i;
      if (cki < 0 && core_clk_en) begin
        cki = i;
        chk(!busy, "R8 busy falls with clock", busy, 0);
      end
      if (ret_restore) rcount++;
    end
    chk(rsi - swi == 6, "R6 settle wait", rsi - swi, 6);
    chk(rcount == 1, "R6 restore width", rcount, 1);
    chk(isi - rsi == 2, "R6 iso release", isi - rsi, 2);
    chk(pli - isi == 1, "R6 pll after iso", pli - isi, 1);
    chk(cki - pli == 5, "R6 lock wait", cki - pli, 5);
    chk(pat_now() == 6'b111010, "R6 active after exit", pat_now(), 6'b111010);

    // R10 same-mode request in active
    wr(2'd1, 16'd2);
    wr(2'd2, 16'd2);
    p0 = pat_now();
    wr(2'd0, 16'd0);
    quiet_ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (busy || pat_now() != p0) quiet_ok = 1'b0;
    end
    chk(quiet_ok, "R10 same mode no action", quiet_ok, 1);

    // R7 wake in active ignored
    wake_pulse();
    quiet_ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (busy || pat_now() != p0) quiet_ok = 1'b0;
    end
    chk(quiet_ok, "R7 wake ignored in active", quiet_ok, 1);

    // R9 request held while busy
    wr(2'd0, 16'd3);
    wr(2'd0, 16'd1);
    saw = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!pwr_sw_en) saw = 1'b1;
    end
    chk(saw, "R9 first sequence completed", saw, 1);
    chk(cur_mode == 2'd1 && pat_now() == 6'b011010, "R9 held request applied", cur_mode, 1);

    // R13 doze to nap passes through active
    wr(2'd0, 16'd2);
    saw = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (core_clk_en) saw = 1'b1;
    end
    chk(saw, "R13 clock on in between", saw, 1);
    chk(cur_mode == 2'd2, "R13 nap reached", cur_mode, 2);

    // R10 same-mode request in nap
    p0 = pat_now();
    wr(2'd0, 16'd2);
    quiet_ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (busy || pat_now() != p0) quiet_ok = 1'b0;
    end
    chk(quiet_ok, "R10 same nap no action", quiet_ok, 1);

    // R7 wake from doze and sleep
    wr(2'd0, 16'd1);
    wait_idle();
    wake_pulse();
    wait_idle();
    chk(cur_mode == 2'd0 && pat_now() == 6'b111010, "R7 wake from doze", cur_mode, 0);
    wr(2'd0, 16'd3);
    wait_idle();
    wake_pulse();
    wait_idle();
    chk(cur_mode == 2'd0 && pat_now() == 6'b111010, "R7 wake from sleep", cur_mode, 0);

    finish_run();
  end
endmodule